// File: doc/BRIEF.md
# ADC Scan-Mode Conversion Sequencer

This block decides which analog channel a multi-channel converter samples next and when. Software programs a control word with a run bit, a two-bit mode field, a repeat bit, an interrupt enable and a channel number. Once the run bit is set, the sequencer issues a one-cycle start strobe with a channel number to an external converter core. It then waits for the core's completion pulse, stores the returned sample in that channel's result register and moves on to the next channel.

Mode 00 converts the single channel named by the channel field. Modes 01, 10 and 11 convert a group of 4, 8 or 12 channels beginning at channel 0, in rising channel order. A group runs once, or it loops without pause while the repeat bit is set. At the end of a single conversion or of a full group pass the block raises a completion flag, and it drives an interrupt line while the enable is set. A parameter caps the group size for instances wired to fewer channels.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the run bit, completion flag, interrupt, start strobe and every result register read 0.
- R2: Mode field encoding is 00 = one conversion of channel `cfg_sel`, 01 = channels 0..3, 10 = channels 0..7, 11 = channels 0..11; the first strobe appears two cycles after the write that sets the run bit.
- R3: An instance whose `MAX_GROUP` is below a mode's size converts only channels 0..`MAX_GROUP`-1 in that mode.
- R4: Each conversion gives exactly one single-cycle `conv_start` pulse; group channels rise by one per conversion, and the next strobe follows the cycle after `conv_done`.
- R5: With the repeat bit at 0, a group is converted once; the cycle after the last `conv_done` the completion flag is 1 and the run bit is 0.
- R6: With the repeat bit at 1 in a group mode, the completion flag is set after every full pass, the next pass restarts at channel 0 in the same cycle, and the run bit stays 1. In mode 00 the repeat bit has no effect.
- R7: `irq` is 1 exactly when the completion flag and the interrupt enable are both 1.
- R8: On `conv_done` the value on `conv_data` is stored in the result register of the channel being converted, and `rd_data` shows the register chosen by `rd_ch` in the same cycle.
- R9: A control write with flag bit 0 clears the completion flag; flag bit 1 leaves it unchanged. Writing run bit 0 during a scan stops it after the conversion in progress: that result is stored, no further strobe follows and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_start | input | 1 | Run bit value to write |
| cfg_done | input | 1 | Completion flag write value (0 clears, 1 keeps) |
| cfg_mode | input | 2 | Scan mode field |
| cfg_cont | input | 1 | Repeat (continuous scan) bit |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_sel | input | CH_W | Channel for mode 00 |
| stat_start | output | 1 | Current run bit |
| stat_done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle strobe to the converter core |
| conv_ch | output | CH_W | Channel for the converter core |
| conv_done | input | 1 | Converter core completion pulse |
| conv_data | input | RES_W | Converter core sample |
| rd_ch | input | CH_W | Result register select |
| rd_data | output | RES_W | Selected result register |

## Verification
The assertions assume that the converter core answers each strobe with exactly one `conv_done` pulse. They also assume the pulse arrives no earlier than the cycle after the strobe, and that no pulse arrives while the sequencer is idle. They further take `cfg_sel` and `rd_ch` to be below the channel count. The bench core model returns every pulse a fixed three cycles after the strobe it sees, and it only ever answers a strobe. All channel numbers the bench writes or reads are kept in range.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_SCAN4  = 2'b01,
        MODE_SCAN8  = 2'b10,
        MODE_SCAN12 = 2'b11
    } scan_mode_e;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       start;
        logic       done;
        scan_mode_e mode;
        logic       cont;
        logic       irq_en;
    } ctrl_word_t;

    // Number of channels a mode converts, limited by the instance cap.
    function automatic int unsigned group_len(input scan_mode_e m, input int unsigned cap);
        int unsigned n;
        case (m)
            MODE_SCAN4:  n = 4;
            MODE_SCAN8:  n = 8;
            MODE_SCAN12: n = 12;
            default:     n = 1;
        endcase
        if (m != MODE_SINGLE && n > cap) begin
            n = cap;
        end
        return n;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl_reg.sv
module adc_seq_ctrl_reg
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  ctrl_word_t      wr_word,
    input  logic [CH_W-1:0] wr_sel,
    input  logic            pass_end,
    input  logic            auto_stop,
    output ctrl_word_t      cur,
    output logic [CH_W-1:0] cur_sel,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            cur_sel <= '0;
        end else begin
            if (wr_en) begin
                cur.start  <= wr_word.start;
                cur.mode   <= wr_word.mode;
                cur.cont   <= wr_word.cont;
                cur.irq_en <= wr_word.irq_en;
                cur_sel    <= wr_sel;
            end else if (auto_stop) begin
                cur.start <= 1'b0;
            end
            if (pass_end) begin
                cur.done <= 1'b1;
            end else if (wr_en && !wr_word.done) begin
                cur.done <= 1'b0;
            end
        end
    end

    assign irq = cur.done & cur.irq_en;

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cur.done) |-> $past(pass_end));

    // R5
    start_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cur.start) |-> ($past(auto_stop) || $past(wr_en && !wr_word.start)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int CH_W      = 4,
    parameter int GROUP_CAP = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  scan_mode_e      mode,
    input  logic            cont,
    input  logic [CH_W-1:0] sel,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            res_we,
    output logic            pass_end,
    output logic            auto_stop
);

    seq_state_e      st_q, st_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic [CH_W-1:0] last_q, last_d;
    logic            single_q, single_d;
    logic            cont_q, cont_d;
    logic            issue_q, issue_d;
    logic            at_last;

    assign at_last = (ch_q == last_q);

    always_comb begin
        st_d      = st_q;
        ch_d      = ch_q;
        last_d    = last_q;
        single_d  = single_q;
        cont_d    = cont_q;
        issue_d   = 1'b0;
        pass_end  = 1'b0;
        auto_stop = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                if (start) begin
                    st_d     = SQ_WAIT;
                    issue_d  = 1'b1;
                    single_d = (mode == MODE_SINGLE);
                    cont_d   = cont;
                    if (mode == MODE_SINGLE) begin
                        ch_d   = sel;
                        last_d = sel;
                    end else begin
                        ch_d   = '0;
                        last_d = CH_W'(group_len(mode, GROUP_CAP) - 1);
                    end
                end
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    if (!start) begin
                        st_d = SQ_IDLE;
                    end else if (at_last) begin
                        pass_end = 1'b1;
                        if (cont_q && !single_q) begin
                            ch_d    = '0;
                            issue_d = 1'b1;
                        end else begin
                            auto_stop = 1'b1;
                            st_d      = SQ_IDLE;
                        end
                    end else begin
                        ch_d    = ch_q + 1'b1;
                        issue_d = 1'b1;
                    end
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            ch_q     <= '0;
            last_q   <= '0;
            single_q <= 1'b0;
            cont_q   <= 1'b0;
            issue_q  <= 1'b0;
        end else begin
            st_q     <= st_d;
            ch_q     <= ch_d;
            last_q   <= last_d;
            single_q <= single_d;
            cont_q   <= cont_d;
            issue_q  <= issue_d;
        end
    end

    assign conv_start = issue_q;
    assign conv_ch    = ch_q;
    assign res_we     = (st_q == SQ_WAIT) && conv_done;

    // R4
    scan_order_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start && $past(st_q == SQ_WAIT) && !single_q) |->
            ((conv_ch == $past(conv_ch) + 1'b1) ||
             (conv_ch == '0 && $past(conv_ch) == last_q)));

    // R3
    group_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !single_q) |-> (conv_ch <= last_q && int'(last_q) < GROUP_CAP && int'(last_q) < NUM_CH));

    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_WAIT && conv_done && !start) |=> (!conv_start && st_q == SQ_IDLE));

endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4,
    parameter int RES_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);

    logic [NUM_CH-1:0][RES_W-1:0] flat;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        logic [RES_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && wr_ch == CH_W'(i)) begin
                slot_q <= wr_data;
            end
        end
        assign flat[i] = slot_q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_ch == CH_W'(k)) begin
                rd_data = flat[k];
            end
        end
    end

    // R8
    result_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && int'(wr_ch) < NUM_CH) |=> (flat[$past(wr_ch)] == $past(wr_data)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int MAX_GROUP = 12,
    parameter int RES_W     = 10,
    parameter int CH_W      = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_start,
    input  logic             cfg_done,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_cont,
    input  logic             cfg_irq_en,
    input  logic [CH_W-1:0]  cfg_sel,
    output logic             stat_start,
    output logic             stat_done,
    output logic             irq,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_ch,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);

    localparam int GROUP_CAP = (MAX_GROUP < NUM_CH) ? MAX_GROUP : NUM_CH;

    ctrl_word_t      wr_word;
    ctrl_word_t      cur;
    logic [CH_W-1:0] cur_sel;
    logic            pass_end;
    logic            auto_stop;
    logic            res_we;

    always_comb begin
        wr_word.start  = cfg_start;
        wr_word.done   = cfg_done;
        wr_word.mode   = scan_mode_e'(cfg_mode);
        wr_word.cont   = cfg_cont;
        wr_word.irq_en = cfg_irq_en;
    end

    adc_seq_ctrl_reg #(
        .CH_W(CH_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_word  (wr_word),
        .wr_sel   (cfg_sel),
        .pass_end (pass_end),
        .auto_stop(auto_stop),
        .cur      (cur),
        .cur_sel  (cur_sel),
        .irq      (irq)
    );

    adc_seq_fsm #(
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W),
        .GROUP_CAP(GROUP_CAP)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .start     (cur.start),
        .mode      (cur.mode),
        .cont      (cur.cont),
        .sel       (cur_sel),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .conv_ch   (conv_ch),
        .res_we    (res_we),
        .pass_end  (pass_end),
        .auto_stop (auto_stop)
    );

    adc_seq_result_bank #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .RES_W (RES_W)
    ) bank_i (
        .clk    (clk),
        .rst    (rst),
        .we     (res_we),
        .wr_ch  (conv_ch),
        .wr_data(conv_data),
        .rd_ch  (rd_ch),
        .rd_data(rd_data)
    );

    assign stat_start = cur.start;
    assign stat_done  = cur.done;

endmodule

// File: tb/adc_scan_seq_ref.sv
module adc_scan_seq_ref #(
    parameter int    NUM_CH = 12,
    parameter int    MAXG   = 12,
    parameter int    RES_W  = 10,
    parameter int    CH_W   = 4,
    parameter int    LAT    = 3,
    parameter string TAG    = "dut"
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_start,
    input  logic             cfg_done,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_cont,
    input  logic             cfg_irq_en,
    input  logic [CH_W-1:0]  cfg_sel,
    input  logic             stat_start,
    input  logic             stat_done,
    input  logic             irq,
    input  logic             conv_start,
    input  logic [CH_W-1:0]  conv_ch,
    input  logic [RES_W-1:0] rd_data,
    output logic             conv_done,
    output logic [RES_W-1:0] conv_data,
    output logic [CH_W-1:0]  rd_ch,
    output int               err_cnt,
    output int               chk_cnt
);

    // behavioural model state
    bit m_start, m_done, m_cont, m_ie, m_busy, m_single, m_loop, m_issue;
    int m_mode, m_sel, m_ch, m_len;
    int m_res[NUM_CH];
    bit pe, as, nis;

    // core model state
    int cnt, pend_ch, seqn;

    function automatic int size_of(input int md);
        int n;
        n = (md == 1) ? 4 : (md == 2) ? 8 : 12;
        if (n > MAXG) n = MAXG;
        if (n > NUM_CH) n = NUM_CH;
        return n;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_start = 0; m_done = 0; m_cont = 0; m_ie = 0; m_busy = 0;
            m_single = 0; m_loop = 0; m_issue = 0;
            m_mode = 0; m_sel = 0; m_ch = 0; m_len = 1;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            pe = 0; as = 0; nis = 0;
            if (!m_busy) begin
                if (m_start) begin
                    m_busy   = 1;
                    m_single = (m_mode == 0);
                    m_loop   = m_cont;
                    m_len    = m_single ? 1 : size_of(m_mode);
                    m_ch     = m_single ? m_sel : 0;
                    nis      = 1;
                end
            end else if (conv_done) begin
                m_res[m_ch] = int'(conv_data);
                if (!m_start) begin
                    m_busy = 0;
                end else if (m_single || m_ch == m_len - 1) begin
                    pe = 1;
                    if (m_loop && !m_single) begin
                        m_ch = 0;
                        nis  = 1;
                    end else begin
                        as     = 1;
                        m_busy = 0;
                    end
                end else begin
                    m_ch = m_ch + 1;
                    nis  = 1;
                end
            end
            if (cfg_wr) begin
                m_start = cfg_start;
                m_mode  = int'(cfg_mode);
                m_cont  = cfg_cont;
                m_ie    = cfg_irq_en;
                m_sel   = int'(cfg_sel);
            end else if (as) begin
                m_start = 0;
            end
            if (pe) m_done = 1;
            else if (cfg_wr && !cfg_done) m_done = 0;
            m_issue = nis;
        end
    end

    task automatic cmp(input bit ok, input string req, input string what, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s %s %s: actual=%0d expected=%0d at %0t", req, TAG, what, act, exp, $time);
        end
    endtask

    initial begin
        err_cnt = 0; chk_cnt = 0;
        conv_done = 0; conv_data = '0; rd_ch = '0;
        cnt = 0; pend_ch = 0; seqn = 0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            cmp(stat_start == m_start, "R5", "run bit", int'(stat_start), int'(m_start));
            cmp(stat_done == m_done, "R6", "done flag", int'(stat_done), int'(m_done));
            cmp(irq == (m_done && m_ie), "R7", "irq", int'(irq), int'(m_done && m_ie));
            cmp(conv_start == m_issue, "R4", "strobe", int'(conv_start), int'(m_issue));
            if (m_issue) cmp(int'(conv_ch) == m_ch, "R2", "channel", int'(conv_ch), m_ch);
            cmp(int'(rd_data) == m_res[int'(rd_ch)], "R8", "result (R1 zero after reset)",
                int'(rd_data), m_res[int'(rd_ch)]);
        end
        rd_ch <= (int'(rd_ch) == NUM_CH - 1) ? '0 : rd_ch + 1'b1;
        conv_done <= 1'b0;
        if (rst) begin
            cnt = 0;
        end else begin
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    conv_done <= 1'b1;
                    conv_data <= RES_W'((pend_ch * 53 + seqn * 7 + 1) % (1 << RES_W));
                    seqn = seqn + 1;
                end
            end
            if (conv_start) begin
                cnt     = LAT;
                pend_ch = int'(conv_ch);
            end
        end
    end

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

    localparam int NUM_CH = 12;
    localparam int CH_W   = 4;
    localparam int RES_W  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic            cfg_wr = 0, cfg_start = 0, cfg_done = 0, cfg_cont = 0, cfg_irq_en = 0;
    logic [1:0]      cfg_mode = '0;
    logic [CH_W-1:0] cfg_sel = '0;

    logic             a_start, a_done, a_irq, a_cs, a_cd;
    logic [CH_W-1:0]  a_ch, a_rd;
    logic [RES_W-1:0] a_cdata, a_rdata;
    logic             b_start, b_done, b_irq, b_cs, b_cd;
    logic [CH_W-1:0]  b_ch, b_rd;
    logic [RES_W-1:0] b_cdata, b_rdata;
    int ra_err, ra_chk, rb_err, rb_chk;

    int  errs = 0, checks = 0;
    bit  finished = 0;
    int  seq_a[$];
    int  seq_b[$];

    adc_scan_seq #(.NUM_CH(NUM_CH), .MAX_GROUP(12), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_done(cfg_done),
        .cfg_mode(cfg_mode), .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en), .cfg_sel(cfg_sel),
        .stat_start(a_start), .stat_done(a_done), .irq(a_irq), .conv_start(a_cs), .conv_ch(a_ch),
        .conv_done(a_cd), .conv_data(a_cdata), .rd_ch(a_rd), .rd_data(a_rdata));

    adc_scan_seq #(.NUM_CH(NUM_CH), .MAX_GROUP(8), .RES_W(RES_W)) dut8_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_done(cfg_done),
        .cfg_mode(cfg_mode), .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en), .cfg_sel(cfg_sel),
        .stat_start(b_start), .stat_done(b_done), .irq(b_irq), .conv_start(b_cs), .conv_ch(b_ch),
        .conv_done(b_cd), .conv_data(b_cdata), .rd_ch(b_rd), .rd_data(b_rdata));

    adc_scan_seq_ref #(.NUM_CH(NUM_CH), .MAXG(12), .RES_W(RES_W), .CH_W(CH_W), .TAG("full")) ref_a (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_done(cfg_done),
        .cfg_mode(cfg_mode), .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en), .cfg_sel(cfg_sel),
        .stat_start(a_start), .stat_done(a_done), .irq(a_irq), .conv_start(a_cs), .conv_ch(a_ch),
        .rd_data(a_rdata), .conv_done(a_cd), .conv_data(a_cdata), .rd_ch(a_rd),
        .err_cnt(ra_err), .chk_cnt(ra_chk));

    adc_scan_seq_ref #(.NUM_CH(NUM_CH), .MAXG(8), .RES_W(RES_W), .CH_W(CH_W), .TAG("cap8")) ref_b (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_done(cfg_done),
        .cfg_mode(cfg_mode), .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en), .cfg_sel(cfg_sel),
        .stat_start(b_start), .stat_done(b_done), .irq(b_irq), .conv_start(b_cs), .conv_ch(b_ch),
        .rd_data(b_rdata), .conv_done(b_cd), .conv_data(b_cdata), .rd_ch(b_rd),
        .err_cnt(rb_err), .chk_cnt(rb_chk));

    always @(negedge clk) begin
        if (!rst) begin
            if (a_cs) seq_a.push_back(int'(a_ch));
            if (b_cs) seq_b.push_back(int'(b_ch));
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs + ra_err + rb_err, checks + ra_chk + rb_chk);
            $finish;
        end
    endtask

    task automatic wr_ctrl(input bit st, input bit dn, input logic [1:0] md, input bit ct,
                           input bit ie, input int sel);
        @(negedge clk);
        cfg_start = st; cfg_done = dn; cfg_mode = md; cfg_cont = ct;
        cfg_irq_en = ie; cfg_sel = CH_W'(sel); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_done_a(input int lim);
        for (int i = 0; i < lim && !a_done; i++) @(negedge clk);
    endtask

    // queue q must hold n entries counting up from first, wrapping at len
    task automatic chk_seq(input int q[$], input int n, input int first, input int len, input string req);
        chk(q.size() == n, req, "conversion count", q.size(), n);
        for (int i = 0; i < n && i < q.size(); i++) begin
            chk(q[i] == first + (i % len), req, "channel order", q[i], first + (i % len));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(a_start == 0, "R1", "run bit after reset", int'(a_start), 0);
        chk(a_done == 0, "R1", "flag after reset", int'(a_done), 0);
        chk(a_irq == 0, "R1", "irq after reset", int'(a_irq), 0);
        chk(a_cs == 0, "R1", "strobe after reset", int'(a_cs), 0);

        // R2 single mode on channel 5, irq enabled
        seq_a.delete(); seq_b.delete();
        wr_ctrl(1, 0, 2'b00, 0, 1, 5);
        wait_done_a(100);
        chk_seq(seq_a, 1, 5, 1, "R2");
        chk(a_start == 0, "R5", "run bit after single", int'(a_start), 0);
        chk(a_irq == 1, "R7", "irq with enable", int'(a_irq), 1);
        wr_ctrl(0, 0, 2'b00, 0, 1, 5);
        chk(a_done == 0, "R9", "flag cleared by write 0", int'(a_done), 0);
        chk(a_irq == 0, "R7", "irq after clear", int'(a_irq), 0);

        // R6 repeat bit ignored in mode 00
        seq_a.delete();
        wr_ctrl(1, 0, 2'b00, 1, 1, 7);
        wait_done_a(100);
        repeat (10) @(negedge clk);
        chk_seq(seq_a, 1, 7, 1, "R6");
        chk(a_start == 0, "R6", "single with repeat stops", int'(a_start), 0);
        wr_ctrl(0, 0, 2'b00, 0, 1, 0);

        // R4 4-channel group once
        seq_a.delete();
        wr_ctrl(1, 0, 2'b01, 0, 1, 9);
        wait_done_a(200);
        chk_seq(seq_a, 4, 0, 4, "R4");
        chk(a_start == 0, "R5", "run bit after scan4", int'(a_start), 0);
        wr_ctrl(0, 1, 2'b01, 0, 1, 0);
        chk(a_done == 1, "R9", "flag kept by write 1", int'(a_done), 1);
        wr_ctrl(0, 0, 2'b01, 0, 1, 0);

        // R5 8-channel group once, irq disabled
        seq_a.delete();
        wr_ctrl(1, 0, 2'b10, 0, 0, 0);
        wait_done_a(300);
        chk_seq(seq_a, 8, 0, 8, "R5");
        chk(a_done == 1, "R5", "flag after scan8", int'(a_done), 1);
        chk(a_irq == 0, "R7", "irq masked", int'(a_irq), 0);
        wr_ctrl(0, 0, 2'b10, 0, 0, 0);

        // R2/R3 12-channel group: full instance vs capped instance
        seq_a.delete(); seq_b.delete();
        wr_ctrl(1, 0, 2'b11, 0, 1, 0);
        wait_done_a(400);
        chk_seq(seq_a, 12, 0, 12, "R2");
        chk_seq(seq_b, 8, 0, 8, "R3");
        chk(b_done == 1 && b_start == 0, "R3", "capped instance finished", int'(b_done), 1);
        wr_ctrl(0, 0, 2'b11, 0, 1, 0);

        // R6 continuous 4-channel scan over three passes
        seq_a.delete();
        wr_ctrl(1, 0, 2'b01, 1, 1, 0);
        for (int p = 0; p < 3; p++) begin
            wait_done_a(200);
            chk(a_start == 1, "R6", "run bit held in repeat", int'(a_start), 1);
            wr_ctrl(1, 0, 2'b01, 1, 1, 0);
        end
        chk(seq_a.size() >= 12, "R6", "passes issued", seq_a.size(), 12);
        for (int i = 0; i < 12 && i < seq_a.size(); i++)
            chk(seq_a[i] == i % 4, "R6", "pass restarts at 0", seq_a[i], i % 4);
        // R9 abort the repeating scan
        wr_ctrl(0, 0, 2'b01, 1, 1, 0);
        repeat (20) @(negedge clk);
        begin
            int n0;
            n0 = seq_a.size();
            repeat (30) @(negedge clk);
            chk(seq_a.size() == n0, "R9", "no strobe after abort", seq_a.size(), n0);
        end
        chk(a_done == 0 && a_start == 0, "R9", "abort leaves flag clear", int'(a_done), 0);

        // R9 abort a single-pass 8-channel scan midway
        seq_a.delete();
        wr_ctrl(1, 0, 2'b10, 0, 0, 0);
        repeat (6) @(negedge clk);
        wr_ctrl(0, 0, 2'b10, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk(seq_a.size() > 0 && seq_a.size() < 8, "R9", "partial scan length", seq_a.size(), 2);
        chk(a_done == 0, "R9", "flag not set on abort", int'(a_done), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule